// File: doc/BRIEF.md
# PIPE Link Bring-Up Sequencer

This block steps a four-lane PCI Express PHY, driven over its PIPE-style control pins, from reset into a first-generation data phase. On a request it moves the link to the second-generation rate and brings it back to a data phase. At each step it drives the PHY's powerdown state, the rate select and the transmit electrical-idle control. It also gives a test-pattern source an enable that is high only while data may flow.

Each power-up step (P1 to P0) runs for a fixed number of cycles. The step counts as successful only if, inside a window of that count, every receive byte reported symbol lock in the same cycle. A failed step restarts. The rate change waits until every lane has pulsed its PHY status at least once. After the second-generation data phase is reached, a ready flag tells the management side that the link is up.

Top module: `lb_link_sequencer`

## Requirements
- R1: A synchronous, active-high `rst` puts the block in phase 0 (Gen 1 idle) with powerdown P1 (2'b10), rate 0, electrical idle 1, data enable 0 and ready 0. This applies at power-up and when `rst` is raised in the middle of operation.
- R2: Phase 0 is left only at a clock edge where `start_i` is high. From the next cycle the phase is 1 (Gen 1 power-up).
- R3: In the power-up phases (codes 1 and 4) powerdown is P0 (2'b00) and electrical idle is 0. A cycle count starts at 0 on entry and goes up by one per cycle without wrapping. The phase is left only at the edge where the count equals DONE_CNT, so each attempt lasts exactly DONE_CNT+1 cycles, even if sync arrived early.
- R4: A cycle qualifies as synced only when the count is within WIN_LO..WIN_HI (inclusive at both ends) and every bit of `rx_sync_i` is 1. If no cycle of the attempt qualified, the same phase starts again with the count at 0.
- R5: If any cycle of a Gen 1 attempt qualified, the next phase is 2 (Gen 1 data): powerdown P0, electrical idle 0, rate 0, data enable 1.
- R6: `rate_sw_req_i` acts only in phase 2. In the next cycle the phase is 3 (rate change) with rate 1, powerdown P1, electrical idle 1 and data enable 0. In every other phase the request has no effect.
- R7: In phase 3 each lane's acknowledge is cleared on entry, set by a one-cycle pulse on its `phy_status_i` bit, and then held. The phase moves to 4 at the edge where all lanes are acknowledged, counting pulses seen at that same edge. Status seen before entry does not count.
- R8: A qualified Gen 2 attempt leads to phase 5 (Gen 2 data): rate 1, powerdown P0, electrical idle 0, data enable 1, ready 1. The block stays there until reset, whatever `start_i` and `rate_sw_req_i` do.
- R9: `mgmt_ready_o` is 1 only in phase 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin bring-up from phase 0 |
| rate_sw_req_i | input | 1 | Request move to Gen 2 from Gen 1 data |
| phy_status_i | input | LANES | Per-lane PHY status pulses |
| rx_sync_i | input | SYNC_W | Per-byte receive sync status |
| phase_o | output | 3 | Current phase code 0..5 |
| powerdown_o | output | 2 | Powerdown state, P0=00, P1=10 |
| rate_o | output | 1 | Rate select, 0 Gen 1, 1 Gen 2 |
| elec_idle_o | output | 1 | Transmit electrical-idle control |
| data_en_o | output | 1 | Enable for the test-pattern source |
| mgmt_ready_o | output | 1 | Link up at Gen 2 |

## Verification
The bench builds the block with DONE_CNT=20, WIN_LO=5 and WIN_HI=20 instead of the much longer defaults, and keeps four lanes and eight sync bits. The short count lets one run step through several full power-up attempts: a failed retry, sync at the lower window bound, sync at the upper bound on the final cycle, a partial sync vector, and sync before the window opens. Because WIN_HI equals DONE_CNT, the bench can check the corner where the last qualifying cycle and the exit decision fall on the same edge.

// File: rtl/lb_pkg.sv
package lb_pkg;

    typedef enum logic [2:0] {
        PH_IDLE_G1  = 3'd0,
        PH_PWRUP_G1 = 3'd1,
        PH_DATA_G1  = 3'd2,
        PH_RATE_CHG = 3'd3,
        PH_PWRUP_G2 = 3'd4,
        PH_DATA_G2  = 3'd5
    } phase_e;

    localparam logic [1:0] PD_P0 = 2'b00;
    localparam logic [1:0] PD_P1 = 2'b10;

    typedef struct packed {
        logic [1:0] pd;
        logic       rate;
        logic       idle;
        logic       data_en;
        logic       ready;
    } ctl_t;

    typedef struct packed {
        phase_e phase;
        ctl_t   ctl;
    } seq_t;

    function automatic ctl_t decode_phase(input phase_e ph);
        ctl_t c;
        c = '{pd: PD_P1, rate: 1'b0, idle: 1'b1, data_en: 1'b0, ready: 1'b0};
        case (ph)
            PH_PWRUP_G1: begin c.pd = PD_P0; c.idle = 1'b0; end
            PH_DATA_G1:  begin c.pd = PD_P0; c.idle = 1'b0; c.data_en = 1'b1; end
            PH_RATE_CHG: begin c.rate = 1'b1; end
            PH_PWRUP_G2: begin c.pd = PD_P0; c.idle = 1'b0; c.rate = 1'b1; end
            PH_DATA_G2:  begin
                c.pd = PD_P0; c.idle = 1'b0; c.rate = 1'b1;
                c.data_en = 1'b1; c.ready = 1'b1;
            end
            default: ;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/lb_phase_counter.sv
module lb_phase_counter #(
    parameter int unsigned CNT_W = 9
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr_i,
    input  logic             en_i,
    output logic [CNT_W-1:0] cnt_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr_i)
            cnt_d = '0;
        else if (en_i && cnt_q != CNT_MAX)
            cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_d;
    end

    assign cnt_o = cnt_q;

    // R3: count never wraps past its ceiling
    p_cnt_no_wrap_r3: assert property (@(posedge clk) disable iff (rst)
        (cnt_q == CNT_MAX && !clr_i) |=> cnt_q == CNT_MAX);

    // R3: every phase entry restarts the count at zero
    p_cnt_clear_r3: assert property (@(posedge clk) disable iff (rst)
        clr_i |=> cnt_q == '0);

endmodule

// File: rtl/lb_lane_ack.sv
module lb_lane_ack #(
    parameter int unsigned LANES = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr_i,
    input  logic             en_i,
    input  logic [LANES-1:0] status_i,
    output logic             all_o
);
    logic [LANES-1:0] ack_d, ack_q;

    always_comb begin
        if (clr_i)     ack_d = '0;
        else if (en_i) ack_d = ack_q | status_i;
        else           ack_d = ack_q;
    end

    always_ff @(posedge clk) begin
        if (rst) ack_q <= '0;
        else     ack_q <= ack_d;
    end

    assign all_o = en_i && (&(ack_q | status_i));

    generate
        for (genvar g = 0; g < LANES; g++) begin : g_lane
            // R7: a lane acknowledge is held until the next clear
            p_ack_sticky_r7: assert property (@(posedge clk) disable iff (rst)
                (ack_q[g] && !clr_i) |=> ack_q[g]);
        end
    endgenerate

endmodule

// File: rtl/lb_sync_window.sv
module lb_sync_window #(
    parameter int unsigned CNT_W  = 9,
    parameter int unsigned SYNC_W = 8,
    parameter int unsigned WIN_LO = 'h051,
    parameter int unsigned WIN_HI = 'h164
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr_i,
    input  logic              en_i,
    input  logic [CNT_W-1:0]  cnt_i,
    input  logic [SYNC_W-1:0] rx_sync_i,
    output logic              hit_o
);
    localparam logic [CNT_W-1:0] LO = CNT_W'(WIN_LO);
    localparam logic [CNT_W-1:0] HI = CNT_W'(WIN_HI);

    logic qual;
    logic seen_d, seen_q;

    assign qual = en_i && (cnt_i >= LO) && (cnt_i <= HI) && (&rx_sync_i);

    always_comb begin
        if (clr_i) seen_d = 1'b0;
        else       seen_d = seen_q | qual;
    end

    always_ff @(posedge clk) begin
        if (rst) seen_q <= 1'b0;
        else     seen_q <= seen_d;
    end

    assign hit_o = seen_q | qual;

    // R4: a new sync record is only taken inside the count window
    p_sync_in_window_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(seen_q) |-> ($past(cnt_i) >= LO && $past(cnt_i) <= HI));

endmodule

// File: rtl/lb_link_sequencer.sv
module lb_link_sequencer
    import lb_pkg::*;
#(
    parameter int unsigned LANES    = 4,
    parameter int unsigned SYNC_W   = 8,
    parameter int unsigned CNT_W    = 9,
    parameter int unsigned DONE_CNT = 'h164,
    parameter int unsigned WIN_LO   = 'h051,
    parameter int unsigned WIN_HI   = 'h164
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic              rate_sw_req_i,
    input  logic [LANES-1:0]  phy_status_i,
    input  logic [SYNC_W-1:0] rx_sync_i,
    output logic [2:0]        phase_o,
    output logic [1:0]        powerdown_o,
    output logic              rate_o,
    output logic              elec_idle_o,
    output logic              data_en_o,
    output logic              mgmt_ready_o
);
    localparam logic [CNT_W-1:0] DONE = CNT_W'(DONE_CNT);
    localparam seq_t SEQ_RESET = '{phase: PH_IDLE_G1, ctl: decode_phase(PH_IDLE_G1)};

    seq_t st_d, st_q;
    logic enter;
    logic in_pwrup, in_rate;
    logic [CNT_W-1:0] cnt;
    logic cnt_done, sync_hit, acks_all;

    assign in_pwrup = (st_q.phase == PH_PWRUP_G1) || (st_q.phase == PH_PWRUP_G2);
    assign in_rate  = (st_q.phase == PH_RATE_CHG);
    assign cnt_done = in_pwrup && (cnt == DONE);

    lb_phase_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst   (rst),
        .clr_i (enter),
        .en_i  (in_pwrup),
        .cnt_o (cnt)
    );

    lb_sync_window #(
        .CNT_W(CNT_W), .SYNC_W(SYNC_W), .WIN_LO(WIN_LO), .WIN_HI(WIN_HI)
    ) u_sync (
        .clk       (clk),
        .rst       (rst),
        .clr_i     (enter),
        .en_i      (in_pwrup),
        .cnt_i     (cnt),
        .rx_sync_i (rx_sync_i),
        .hit_o     (sync_hit)
    );

    lb_lane_ack #(.LANES(LANES)) u_ack (
        .clk      (clk),
        .rst      (rst),
        .clr_i    (enter),
        .en_i     (in_rate),
        .status_i (phy_status_i),
        .all_o    (acks_all)
    );

    always_comb begin
        st_d  = st_q;
        enter = 1'b0;
        case (st_q.phase)
            PH_IDLE_G1: if (start_i) begin
                st_d.phase = PH_PWRUP_G1;
                enter      = 1'b1;
            end
            PH_PWRUP_G1: if (cnt_done) begin
                st_d.phase = sync_hit ? PH_DATA_G1 : PH_PWRUP_G1;
                enter      = 1'b1;
            end
            PH_DATA_G1: if (rate_sw_req_i) begin
                st_d.phase = PH_RATE_CHG;
                enter      = 1'b1;
            end
            PH_RATE_CHG: if (acks_all) begin
                st_d.phase = PH_PWRUP_G2;
                enter      = 1'b1;
            end
            PH_PWRUP_G2: if (cnt_done) begin
                st_d.phase = sync_hit ? PH_DATA_G2 : PH_PWRUP_G2;
                enter      = 1'b1;
            end
            default: ;
        endcase
        st_d.ctl = decode_phase(st_d.phase);
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= SEQ_RESET;
        else     st_q <= st_d;
    end

    assign phase_o      = st_q.phase;
    assign powerdown_o  = st_q.ctl.pd;
    assign rate_o       = st_q.ctl.rate;
    assign elec_idle_o  = st_q.ctl.idle;
    assign data_en_o    = st_q.ctl.data_en;
    assign mgmt_ready_o = st_q.ctl.ready;

    // R3: a power-up phase is left only once the count has reached its end
    p_exit_at_done_r3: assert property (@(posedge clk) disable iff (rst)
        ($past(st_q.phase) == PH_PWRUP_G1 && st_q.phase == PH_DATA_G1) |->
            $past(cnt) == DONE);

    // R5: Gen 1 data is only ever reached from Gen 1 power-up
    p_data_g1_entry_r5: assert property (@(posedge clk) disable iff (rst)
        (st_q.phase == PH_DATA_G1 && $past(st_q.phase) != PH_DATA_G1) |->
            $past(st_q.phase) == PH_PWRUP_G1);

    // R7: rate change ends only with every lane acknowledged
    p_rate_done_acks_r7: assert property (@(posedge clk) disable iff (rst)
        ($past(st_q.phase) == PH_RATE_CHG && st_q.phase == PH_PWRUP_G2) |->
            $past(acks_all));

    // R6: the rate request moves nothing outside Gen 1 data
    p_req_scope_r6: assert property (@(posedge clk) disable iff (rst)
        (st_q.phase == PH_DATA_G2 || st_q.phase == PH_IDLE_G1 && !start_i) |=>
            $stable(st_q.phase));

    // R9: ready only in Gen 2 data
    p_ready_only_g2_r9: assert property (@(posedge clk) disable iff (rst)
        mgmt_ready_o |-> (phase_o == 3'd5 && rate_o));

endmodule

// File: tb/lb_link_sequencer_bench.sv
module lb_link_sequencer_bench;

    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 21;

    typedef struct packed {
        logic [3:0] req;
        logic       start;
        logic       rsw;
        logic [3:0] phy;
        logic [7:0] sync;
        logic [7:0] n;
        logic [2:0] ph;
        logic [1:0] pd;
        logic       rate;
        logic       idle;
        logic       den;
        logic       rdy;
    } vec_t;

    // req, start, rsw, phy, sync, cycles | phase, pd, rate, idle, den, ready
    localparam vec_t TBL [NVEC] = '{
        '{4'd2, 1'b0, 1'b0, 4'h0, 8'h00, 8'd3,  3'd0, 2'b10, 1'b0, 1'b1, 1'b0, 1'b0}, // R2 wait
        '{4'd3, 1'b1, 1'b0, 4'h0, 8'h00, 8'd1,  3'd1, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0}, // R2/R3 entry
        '{4'd4, 1'b0, 1'b0, 4'h0, 8'hFF, 8'd3,  3'd1, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0}, // R4 early sync
        '{4'd3, 1'b0, 1'b0, 4'h0, 8'h00, 8'd17, 3'd1, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0}, // R3 count 20
        '{4'd4, 1'b0, 1'b0, 4'h0, 8'h00, 8'd1,  3'd1, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0}, // R4 retry
        '{4'd3, 1'b0, 1'b0, 4'h0, 8'h00, 8'd6,  3'd1, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0},
        '{4'd4, 1'b0, 1'b0, 4'h0, 8'hFF, 8'd1,  3'd1, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0}, // R4 in window
        '{4'd3, 1'b0, 1'b0, 4'h0, 8'h00, 8'd13, 3'd1, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0}, // R3 no early exit
        '{4'd5, 1'b0, 1'b0, 4'h0, 8'h00, 8'd1,  3'd2, 2'b00, 1'b0, 1'b0, 1'b1, 1'b0}, // R5
        '{4'd7, 1'b0, 1'b0, 4'hF, 8'h00, 8'd2,  3'd2, 2'b00, 1'b0, 1'b0, 1'b1, 1'b0}, // R7 pre-entry
        '{4'd6, 1'b0, 1'b1, 4'h0, 8'h00, 8'd1,  3'd3, 2'b10, 1'b1, 1'b1, 1'b0, 1'b0}, // R6
        '{4'd7, 1'b0, 1'b0, 4'h1, 8'h00, 8'd1,  3'd3, 2'b10, 1'b1, 1'b1, 1'b0, 1'b0},
        '{4'd7, 1'b0, 1'b0, 4'h0, 8'h00, 8'd3,  3'd3, 2'b10, 1'b1, 1'b1, 1'b0, 1'b0},
        '{4'd7, 1'b0, 1'b0, 4'h6, 8'h00, 8'd1,  3'd3, 2'b10, 1'b1, 1'b1, 1'b0, 1'b0},
        '{4'd7, 1'b0, 1'b0, 4'h1, 8'h00, 8'd1,  3'd3, 2'b10, 1'b1, 1'b1, 1'b0, 1'b0},
        '{4'd7, 1'b0, 1'b0, 4'h8, 8'h00, 8'd1,  3'd4, 2'b00, 1'b1, 1'b0, 1'b0, 1'b0}, // R7 done
        '{4'd3, 1'b0, 1'b0, 4'h0, 8'h00, 8'd5,  3'd4, 2'b00, 1'b1, 1'b0, 1'b0, 1'b0},
        '{4'd4, 1'b0, 1'b0, 4'h0, 8'hFF, 8'd1,  3'd4, 2'b00, 1'b1, 1'b0, 1'b0, 1'b0}, // R4 low bound
        '{4'd3, 1'b0, 1'b0, 4'h0, 8'h00, 8'd14, 3'd4, 2'b00, 1'b1, 1'b0, 1'b0, 1'b0},
        '{4'd8, 1'b0, 1'b0, 4'h0, 8'h00, 8'd1,  3'd5, 2'b00, 1'b1, 1'b0, 1'b1, 1'b1}, // R8 R9
        '{4'd8, 1'b1, 1'b1, 4'h0, 8'h00, 8'd3,  3'd5, 2'b00, 1'b1, 1'b0, 1'b1, 1'b1}  // R8 hold
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start = 1'b0;
    logic       rsw = 1'b0;
    logic [3:0] phy = '0;
    logic [7:0] sync = '0;
    logic [2:0] phase;
    logic [1:0] pd;
    logic       rate, idle, den, rdy;

    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    lb_link_sequencer #(
        .LANES(4), .SYNC_W(8), .CNT_W(9),
        .DONE_CNT(20), .WIN_LO(5), .WIN_HI(20)
    ) u_lb_link_sequencer (
        .clk           (clk),
        .rst           (rst),
        .start_i       (start),
        .rate_sw_req_i (rsw),
        .phy_status_i  (phy),
        .rx_sync_i     (sync),
        .phase_o       (phase),
        .powerdown_o   (pd),
        .rate_o        (rate),
        .elec_idle_o   (idle),
        .data_en_o     (den),
        .mgmt_ready_o  (rdy)
    );

    task automatic check(input int req, input logic [2:0] eph, input logic [1:0] epd,
                         input logic erate, input logic eidle, input logic eden,
                         input logic erdy);
        logic [8:0] act, exp;
        act = {phase, pd, rate, idle, den, rdy};
        exp = {eph, epd, erate, eidle, eden, erdy};
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL R%0d: {phase,pd,rate,idle,den,rdy} actual %b expected %b",
                     req, act, exp);
        end
    endtask

    task automatic drive(input logic s, input logic r, input logic [3:0] p,
                         input logic [7:0] y, input int n);
        start = s; rsw = r; phy = p; sync = y;
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        drive(1'b0, 1'b0, 4'h0, 8'h00, 2);
        rst = 1'b0;
    endtask

    initial begin
        do_reset();
        check(1, 3'd0, 2'b10, 1'b0, 1'b1, 1'b0, 1'b0); // R1 power-up state

        for (int i = 0; i < NVEC; i++) begin
            drive(TBL[i].start, TBL[i].rsw, TBL[i].phy, TBL[i].sync, int'(TBL[i].n));
            check(int'(TBL[i].req), TBL[i].ph, TBL[i].pd, TBL[i].rate,
                  TBL[i].idle, TBL[i].den, TBL[i].rdy);
        end

        // R1: reset raised from Gen 2 data
        do_reset();
        check(1, 3'd0, 2'b10, 1'b0, 1'b1, 1'b0, 1'b0);

        // R6: request while idle does nothing
        drive(1'b0, 1'b1, 4'h0, 8'h00, 3);
        check(6, 3'd0, 2'b10, 1'b0, 1'b1, 1'b0, 1'b0);

        // R4/R5: sync only on the last cycle, at the upper bound
        drive(1'b1, 1'b0, 4'h0, 8'h00, 1);
        drive(1'b0, 1'b0, 4'h0, 8'h00, 20);
        check(3, 3'd1, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0);
        drive(1'b0, 1'b0, 4'h0, 8'hFF, 1);
        check(5, 3'd2, 2'b00, 1'b0, 1'b0, 1'b1, 1'b0);

        // R4: one byte out of sync through the whole window -> retry
        do_reset();
        drive(1'b1, 1'b0, 4'h0, 8'h00, 1);
        drive(1'b0, 1'b0, 4'h0, 8'hFE, 21);
        check(4, 3'd1, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0);
        drive(1'b0, 1'b0, 4'h0, 8'h00, 21);
        check(4, 3'd1, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0);

        // R4: sync only at count 4, one below the window
        drive(1'b0, 1'b0, 4'h0, 8'h00, 4);
        drive(1'b0, 1'b0, 4'h0, 8'hFF, 1);
        drive(1'b0, 1'b0, 4'h0, 8'h00, 16);
        check(4, 3'd1, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: run did not end, actual running expected done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule